// File: doc/BRIEF.md
# Keyed Soft-Reset and Software-Interrupt Register Block

This block is a small memory-mapped control slice with two one-bit registers behind a word-wide write and read port. The first register raises a software interrupt. Software sets it by writing a word with bit 0 high and clears it by writing a word with bit 0 low. The second register requests a system reset. It latches only when one exact 32-bit key is written to its offset. No software write can clear it afterwards: it returns to zero only when the block is reset.

The reset-request bit drives an active-high output. The surrounding system answers it by resetting the core, and that reset also clears this block. Both outputs come straight from their flops. The asynchronous active-low reset input is released through a small synchronizer inside the block, so the registers leave reset two clock edges after the input rises.

Top module: `ctl_keyed_regs`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are 0 and both registers read 0. The registers take their first write on the third rising edge after the reset input goes high.
- R2: A write to offset 0xFFC loads bit 0 of the write data into the software-interrupt register. A 1 asserts `swint_o` from the next clock and a 0 deasserts it.
- R3: A read at offset 0xFFC returns the software-interrupt bit in bit 0, with bits 31:1 always 0, whatever was written there.
- R4: Writing exactly 0x80000A5F to offset 0xFF0 sets the reset-request register, and `sysrst_req_o` is 1 from the next clock.
- R5: Writing any other value to offset 0xFF0 leaves the reset-request register unchanged, including values that share some bits with the key.
- R6: Once set, the reset-request register stays 1 under every write, including writes of 0 and repeated key writes. Only a block reset returns it to 0.
- R7: A read at offset 0xFF0 returns the reset-request bit in bit 31, with bits 30:0 always 0.
- R8: Writes to any address other than 0xFFC and 0xFF0 change neither register. This includes misaligned byte addresses next to them. Reads at such addresses return 0.
- R9: Both outputs change only on the clock edge that follows a write to their own register. With no write enable, they hold their value whatever the address and data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from register state |
| swint_o | output | 1 | Software interrupt, straight from its flop |
| sysrst_req_o | output | 1 | Active-high system reset request, straight from its flop |

## Verification
Neither register has hidden state beyond its single bit, so a wrong bit shows on the matching output one clock after the write that caused it. It also shows on the same cycle through a read at that offset. A bad key comparator can set the request too early on a near-miss value, or fail to set it on the true key. A broken sticky path lets a later write drop `sysrst_req_o`. The bench catches each of these on the first comparison after the faulty edge. It compares both outputs and the read data against a behavioural model on every clock, so an error in the reset synchronizer shows up as a write accepted or lost during the release window.

// File: rtl/ctl_keyed_pkg.sv
package ctl_keyed_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ALIGN_W  = $clog2(DATA_W / 8);
  localparam int unsigned SWI_BIT  = 0;
  localparam int unsigned REQ_BIT  = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_SWI = 12'hFFC;
  localparam logic [ADDR_W-1:0] OFS_REQ = 12'hFF0;
  localparam logic [DATA_W-1:0] REQ_KEY = 32'h8000_0A5F;

  typedef struct packed {
    logic wr_swi;
    logic wr_req;
    logic rd_swi;
    logic rd_req;
  } sel_t;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_addr_decode.sv
module ctl_addr_decode
  import ctl_keyed_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic aligned;

  always_comb begin
    aligned    = (addr[ALIGN_W-1:0] == '0);
    sel.rd_swi = aligned && (addr == OFS_SWI);
    sel.rd_req = aligned && (addr == OFS_REQ);
    sel.wr_swi = we && sel.rd_swi;
    sel.wr_req = we && sel.rd_req;
  end
endmodule

// File: rtl/ctl_swint_reg.sv
module ctl_swint_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic swi_q
);
  logic swi_d;

  always_comb begin
    swi_d = swi_q;
    if (wr_en) swi_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swi_q <= 1'b0;
    else        swi_q <= swi_d;
  end

  p_swi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (swi_q == $past(wr_bit)));

  p_swi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(swi_q));
endmodule

// File: rtl/ctl_rstreq_reg.sv
module ctl_rstreq_reg
  import ctl_keyed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              req_q
);
  logic key_ok;
  logic req_d;

  always_comb begin
    key_ok = (wr_data == REQ_KEY);
    req_d  = req_q;
    if (wr_en && key_ok) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  p_key_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data == 32'h8000_0A5F)) |=> req_q);

  p_only_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(wr_en && (wr_data == 32'h8000_0A5F)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);
endmodule

// File: rtl/ctl_keyed_regs.sv
module ctl_keyed_regs
  import ctl_keyed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              swint_o,
  output logic              sysrst_req_o
);
  logic rst_sync_n;
  sel_t sel;
  logic swi_q;
  logic req_q;

  ctl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ctl_addr_decode u_decode (
    .we   (bus_we),
    .addr (bus_addr),
    .sel  (sel)
  );

  ctl_swint_reg u_swint (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (sel.wr_swi),
    .wr_bit (bus_wdata[SWI_BIT]),
    .swi_q  (swi_q)
  );

  ctl_rstreq_reg u_rstreq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (sel.wr_req),
    .wr_data (bus_wdata),
    .req_q   (req_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel.rd_swi) bus_rdata[SWI_BIT] = swi_q;
    if (sel.rd_req) bus_rdata[REQ_BIT] = req_q;
  end

  assign swint_o      = swi_q;
  assign sysrst_req_o = req_q;

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sel.wr_swi, sel.wr_req}));

  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && (bus_addr != 12'hFFC) && (bus_addr != 12'hFF0))
      |=> ($stable(swint_o) && $stable(sysrst_req_o)));

  p_req_rdata_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 12'hFF0) |-> (bus_rdata[30:0] == '0));
endmodule

// File: tb/ctl_keyed_regs_test.sv
module ctl_keyed_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        swint_o;
  logic        sysrst_req_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  string cur_req  = "R1";

  logic   m_swi;
  logic   m_req;
  integer rel_cnt;

  always #10 clk = ~clk;

  ctl_keyed_regs uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .swint_o      (swint_o),
    .sysrst_req_o (sysrst_req_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_swi   = 1'b0;
      m_req   = 1'b0;
      rel_cnt = 0;
    end else begin
      if (rel_cnt >= 2 && bus_we) begin
        if (bus_addr == 12'hFFC) m_swi = bus_wdata[0];
        if (bus_addr == 12'hFF0 && bus_wdata == 32'h8000_0A5F) m_req = 1'b1;
      end
      if (rel_cnt < 2) rel_cnt = rel_cnt + 1;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = 32'h0;
    if (bus_addr == 12'hFFC) exp_rd = {31'h0, m_swi};
    if (bus_addr == 12'hFF0) exp_rd = {m_req, 31'h0};
    check("swint_o", {31'h0, swint_o}, {31'h0, m_swi});
    check("sysrst_req_o", {31'h0, sysrst_req_o}, {31'h0, m_req});
    check("bus_rdata", bus_rdata, exp_rd);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
    step();
  endtask

  task automatic rd(input logic [11:0] a);
    bus_we = 1'b0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 12'hFF0; bus_wdata = 32'h8000_0A5F;
    cur_req = "R1";
    for (int i = 0; i < 2; i++) step();
    bus_we = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) step();
    bus_we = 1'b0;
    step();
    check("req after release window", {31'h0, sysrst_req_o}, 32'h0);
    rd(12'hFFC); rd(12'hFF0);

    cur_req = "R2";
    wr(12'hFFC, 32'h0000_0001);
    check("swint set", {31'h0, swint_o}, 32'h1);
    wr(12'hFFC, 32'h0000_0000);
    check("swint clear", {31'h0, swint_o}, 32'h0);
    wr(12'hFFC, 32'h0000_0001);

    cur_req = "R3";
    wr(12'hFFC, 32'hFFFF_FFFE);
    rd(12'hFFC);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rd(12'hFFC);
    check("swi readback", bus_rdata, 32'h0000_0001);

    cur_req = "R8";
    wr(12'hFFD, 32'h0000_0000);
    wr(12'hFF1, 32'h8000_0A5F);
    wr(12'hFF4, 32'h8000_0A5F);
    wr(12'h000, 32'h0000_0000);
    wr(12'hFF8, 32'h0000_0000);
    rd(12'hFFD); rd(12'hFF3); rd(12'h004);
    check("stray swi", {31'h0, swint_o}, 32'h1);
    check("stray req", {31'h0, sysrst_req_o}, 32'h0);

    cur_req = "R5";
    wr(12'hFF0, 32'h8000_0000);
    wr(12'hFF0, 32'h0000_0A5F);
    wr(12'hFF0, 32'h8000_0A5E);
    wr(12'hFF0, 32'hFFFF_FFFF);
    wr(12'hFF0, 32'h8000_0A5D);
    check("near-miss keys", {31'h0, sysrst_req_o}, 32'h0);

    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin
      bus_we = 1'b0; bus_addr = (i % 2) ? 12'hFF0 : 12'hFFC;
      bus_wdata = (i % 2) ? 32'h8000_0A5F : 32'h0;
      step();
    end
    check("hold swi", {31'h0, swint_o}, 32'h1);

    cur_req = "R4";
    wr(12'hFF0, 32'h8000_0A5F);
    check("key sets req", {31'h0, sysrst_req_o}, 32'h1);

    cur_req = "R7";
    rd(12'hFF0);
    check("req readback", bus_rdata, 32'h8000_0000);

    cur_req = "R6";
    wr(12'hFF0, 32'h0000_0000);
    wr(12'hFF0, 32'h7FFF_FFFF);
    wr(12'hFF0, 32'h8000_0A5F);
    wr(12'hFFC, 32'h0000_0000);
    check("req sticky", {31'h0, sysrst_req_o}, 32'h1);
    do_reset();
    check("req cleared by reset", {31'h0, sysrst_req_o}, 32'h0);

    cur_req = "R4";
    wr(12'hFF0, 32'h8000_0A5F);
    check("key after reset", {31'h0, sysrst_req_o}, 32'h1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule